// File: doc/BRIEF.md
# Indexed Configuration Register Bank with Banked Device Space

This block is the configuration space of a multi-function peripheral controller, reached from a host 8-bit I/O port bus through two adjacent ports. The host first writes a register offset to the lower port of the pair, the index port. It then reads or writes the chosen register through the upper port, the data port. A strap input chooses which of two fixed port pairs the block answers on.

Offsets below 30h are global and shared by every function. Offset 07h holds the device-select number. Offsets 30h and up form a bank that belongs to the currently selected logical device. Changing the device-select number exposes a different device's bank at the same offsets. Each of the four devices has an enable bit and a 16-bit I/O base. The block drives each device's base and enable onto output ports, so that downstream logic can decode that device's own registers at the programmed base.

Top module: `cfg_index_bank`

## Requirements
- R1: With `altPortSel`=0 the index port is 002Eh and the data port is 002Fh. With `altPortSel`=1 they are 004Eh and 004Fh. An access to any other address, including the unselected pair, changes no register and produces no read response.
- R2: A write to the index port stores the 8-bit offset. A read of the index port returns the stored offset.
- R3: A read strobe on the selected pair, sampled at a rising edge, makes `ioRdValid` 1 and `ioRdata` the value after that edge for exactly one cycle. While `ioRdValid` is 0, `ioRdata` is 00h.
- R4: Global offset 07h is the device-select number. It is 8 bits wide, written and read back through the data port.
- R5: Global offsets 00h to 2Fh other than 07h read 00h, and writes to them are ignored.
- R6: Offsets 30h to FFh reach only the bank of the device given by the device-select number (devices 0 to 3). Each device's bank is independent of the others.
- R7: Banked offset 30h is the enable register. Bit 0 is stored as the device enable, and bits 7:1 read as 0.
- R8: Banked offset 60h is the high byte and 61h the low byte of the device's base. `devBase[16*d+15:16*d]` shows {60h,61h} of device d, and `devBaseValid[d]` equals device d's enable bit. Both update on the edge that takes the write.
- R9: While the device-select number is 4 or greater, banked reads return FFh and banked writes change no device.
- R10: Banked offsets other than 30h, 60h and 61h read 00h, and writes to them are ignored.
- R11: Reset (`rstN` low) clears the index, the device-select number and every device register to 00h, and drives `ioRdValid`, `ioRdata`, `devBase` and `devBaseValid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 16 | I/O port address |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioWdata | input | 8 | Write data |
| altPortSel | input | 1 | Strap: 0 selects 2Eh/2Fh, 1 selects 4Eh/4Fh |
| ioRdata | output | 8 | Registered read data, 00h when not valid |
| ioRdValid | output | 1 | Read data valid, one cycle after a read strobe |
| devBase | output | 64 | Programmed I/O base of each device, 16 bits per device |
| devBaseValid | output | 4 | Enable bit of each device |

## Verification
A read strobe is sampled at one rising edge. Its data and valid flag are due right after that edge and are gone after the next one. A write strobe changes register state, and therefore `devBase` and `devBaseValid`, on the same edge. The bench drives each access at a falling edge, holds it across exactly one rising edge, and samples every output at the following falling edge. Nothing is sampled near an active edge. A separate check confirms that the read valid flag drops one cycle later.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic dataWr;
    logic dataRd;
  } cfgStrobe_t;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OFF_DEVSEL  = 8'h07;
  localparam logic [BYTE_W-1:0] OFF_BANK_LO = 8'h30;
  localparam logic [BYTE_W-1:0] OFF_ENABLE  = 8'h30;
  localparam logic [BYTE_W-1:0] OFF_BASE_HI = 8'h60;
  localparam logic [BYTE_W-1:0] OFF_BASE_LO = 8'h61;
  localparam logic [BYTE_W-1:0] FILL_NODEV  = 8'hFF;

endpackage

// File: rtl/cfg_bank_ctrl.sv
module cfg_bank_ctrl
  import cfg_bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PORT_DEF = 16'h002E,
  parameter logic [ADDR_W-1:0] PORT_ALT = 16'h004E
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              altPortSel,
  output cfgStrobe_t        strb
);

  logic [ADDR_W-1:0] idxPort;
  logic [ADDR_W-1:0] dataPort;
  logic              hitIdx;
  logic              hitData;

  always_comb begin
    idxPort  = altPortSel ? PORT_ALT : PORT_DEF;
    dataPort = idxPort + ADDR_W'(1);
    hitIdx   = (ioAddr == idxPort);
    hitData  = (ioAddr == dataPort);
  end

  always_comb begin
    strb        = '0;
    strb.idxWr  = ioWr & hitIdx;
    strb.idxRd  = ioRd & hitIdx;
    strb.dataWr = ioWr & hitData;
    strb.dataRd = ioRd & hitData;
  end

endmodule

// File: rtl/cfg_bank_dp.sv
module cfg_bank_dp
  import cfg_bank_pkg::*;
#(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned BASE_W  = 2 * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrobe_t                strb,
  input  logic [BYTE_W-1:0]         ioWdata,
  output logic [BYTE_W-1:0]         ioRdata,
  output logic                      ioRdValid,
  output logic [NUM_DEV*BASE_W-1:0] devBase,
  output logic [NUM_DEV-1:0]        devBaseValid
);

  localparam int unsigned SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [BYTE_W-1:0] indexQ;
  logic [BYTE_W-1:0] devSelQ;
  logic              inBank;
  logic              devOk;
  logic [SEL_W-1:0]  devIdx;

  logic [NUM_DEV-1:0] enQ;
  logic [BYTE_W-1:0]  baseHiQ [NUM_DEV];
  logic [BYTE_W-1:0]  baseLoQ [NUM_DEV];

  logic [BYTE_W-1:0] globalRd;
  logic [BYTE_W-1:0] bankRd;
  logic [BYTE_W-1:0] rdMux;
  logic              rdAny;

  always_comb begin
    inBank = (indexQ >= OFF_BANK_LO);
    devOk  = (devSelQ < BYTE_W'(NUM_DEV));
    devIdx = devSelQ[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexQ <= '0;
    end else if (strb.idxWr) begin
      indexQ <= ioWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devSelQ <= '0;
    end else if (strb.dataWr && indexQ == OFF_DEVSEL) begin
      devSelQ <= ioWdata;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic bankWr;
    assign bankWr = strb.dataWr & inBank & devOk & (devIdx == SEL_W'(d));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[d]     <= 1'b0;
        baseHiQ[d] <= '0;
        baseLoQ[d] <= '0;
      end else if (bankWr) begin
        unique case (indexQ)
          OFF_ENABLE:  enQ[d]     <= ioWdata[0];
          OFF_BASE_HI: baseHiQ[d] <= ioWdata;
          OFF_BASE_LO: baseLoQ[d] <= ioWdata;
          default: ;
        endcase
      end
    end

    assign devBase[d*BASE_W +: BASE_W] = {baseHiQ[d], baseLoQ[d]};
    assign devBaseValid[d]             = enQ[d];
  end

  always_comb begin
    globalRd = (indexQ == OFF_DEVSEL) ? devSelQ : '0;
    bankRd   = '0;
    if (!devOk) begin
      bankRd = FILL_NODEV;
    end else begin
      unique case (indexQ)
        OFF_ENABLE:  bankRd = {{(BYTE_W-1){1'b0}}, enQ[devIdx]};
        OFF_BASE_HI: bankRd = baseHiQ[devIdx];
        OFF_BASE_LO: bankRd = baseLoQ[devIdx];
        default:     bankRd = '0;
      endcase
    end
  end

  always_comb begin
    rdAny = strb.idxRd | strb.dataRd;
    if (strb.idxRd) begin
      rdMux = indexQ;
    end else if (strb.dataRd) begin
      rdMux = inBank ? bankRd : globalRd;
    end else begin
      rdMux = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioRdValid <= 1'b0;
      ioRdata   <= '0;
    end else begin
      ioRdValid <= rdAny;
      ioRdata   <= rdMux;
    end
  end

endmodule

// File: rtl/cfg_index_bank.sv
module cfg_index_bank
  import cfg_bank_pkg::*;
#(
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PORT_DEF = 16'h002E,
  parameter logic [ADDR_W-1:0] PORT_ALT = 16'h004E,
  localparam int unsigned BASE_W  = 2 * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         ioAddr,
  input  logic                      ioWr,
  input  logic                      ioRd,
  input  logic [BYTE_W-1:0]         ioWdata,
  input  logic                      altPortSel,
  output logic [BYTE_W-1:0]         ioRdata,
  output logic                      ioRdValid,
  output logic [NUM_DEV*BASE_W-1:0] devBase,
  output logic [NUM_DEV-1:0]        devBaseValid
);

  cfgStrobe_t strb;

  cfg_bank_ctrl #(
    .ADDR_W   (ADDR_W),
    .PORT_DEF (PORT_DEF),
    .PORT_ALT (PORT_ALT)
  ) u_ctrl (
    .ioAddr     (ioAddr),
    .ioWr       (ioWr),
    .ioRd       (ioRd),
    .altPortSel (altPortSel),
    .strb       (strb)
  );

  cfg_bank_dp #(
    .NUM_DEV (NUM_DEV),
    .BASE_W  (BASE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .ioWdata      (ioWdata),
    .ioRdata      (ioRdata),
    .ioRdValid    (ioRdValid),
    .devBase      (devBase),
    .devBaseValid (devBaseValid)
  );

endmodule

// File: rtl/cfg_index_bank_chk.sv
module cfg_index_bank_chk #(
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PORT_DEF = 16'h002E,
  parameter logic [ADDR_W-1:0] PORT_ALT = 16'h004E
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      ioAddr,
  input logic                   ioWr,
  input logic                   ioRd,
  input logic [7:0]             ioWdata,
  input logic                   altPortSel,
  input logic [7:0]             ioRdata,
  input logic                   ioRdValid,
  input logic [NUM_DEV*16-1:0]  devBase,
  input logic [NUM_DEV-1:0]     devBaseValid
);

  logic [ADDR_W-1:0] idxPort;
  logic              onPair;
  logic              onIdx;
  logic              onData;

  always_comb begin
    idxPort = altPortSel ? PORT_ALT : PORT_DEF;
    onIdx   = (ioAddr == idxPort);
    onData  = (ioAddr == idxPort + ADDR_W'(1));
    onPair  = onIdx | onData;
  end

  AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && onPair) |=> ioRdValid); // R3

  AST_NO_RESPONSE_OFF_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && onPair) |=> !ioRdValid); // R1

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ioRdValid |-> (ioRdata == 8'h00)); // R3

  AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && !ioRd && onIdx) ##1 (ioRd && !ioWr && onIdx)
      |=> (ioRdata == $past(ioWdata, 2))); // R2

  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWr && onData) |=> ($stable(devBase) && $stable(devBaseValid))); // R8

  AST_RESET_OUTPUTS: assert property (@(posedge clk)
    !rstN |-> (!ioRdValid && devBaseValid == '0 && devBase == '0)); // R11

endmodule

bind cfg_index_bank cfg_index_bank_chk #(
  .NUM_DEV  (NUM_DEV),
  .ADDR_W   (ADDR_W),
  .PORT_DEF (PORT_DEF),
  .PORT_ALT (PORT_ALT)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ioAddr       (ioAddr),
  .ioWr         (ioWr),
  .ioRd         (ioRd),
  .ioWdata      (ioWdata),
  .altPortSel   (altPortSel),
  .ioRdata      (ioRdata),
  .ioRdValid    (ioRdValid),
  .devBase      (devBase),
  .devBaseValid (devBaseValid)
);

// File: tb/cfg_index_bank_bench.sv
module cfg_index_bank_bench;

  localparam int unsigned NUM_DEV = 4;
  localparam int unsigned NVEC    = 47;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_NR = 2'd2;

  // {op[1:0], alt, addr[15:0], data/expected[7:0], req[3:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {OP_WR, 1'b0, 16'h002E, 8'h07, 4'd2},  // R2 set index
    {OP_RD, 1'b0, 16'h002E, 8'h07, 4'd2},  // R2 index readback
    {OP_WR, 1'b0, 16'h002F, 8'h02, 4'd4},  // R4 select device 2
    {OP_RD, 1'b0, 16'h002F, 8'h02, 4'd4},
    {OP_WR, 1'b0, 16'h002E, 8'h30, 4'd7},  // R7
    {OP_WR, 1'b0, 16'h002F, 8'h01, 4'd7},
    {OP_RD, 1'b0, 16'h002F, 8'h01, 4'd7},
    {OP_WR, 1'b0, 16'h002E, 8'h60, 4'd8},  // R8
    {OP_WR, 1'b0, 16'h002F, 8'h12, 4'd8},
    {OP_WR, 1'b0, 16'h002E, 8'h61, 4'd8},
    {OP_WR, 1'b0, 16'h002F, 8'h34, 4'd8},
    {OP_RD, 1'b0, 16'h002F, 8'h34, 4'd8},
    {OP_WR, 1'b0, 16'h002E, 8'h07, 4'd6},  // R6 switch to device 1
    {OP_WR, 1'b0, 16'h002F, 8'h01, 4'd6},
    {OP_WR, 1'b0, 16'h002E, 8'h60, 4'd6},
    {OP_RD, 1'b0, 16'h002F, 8'h00, 4'd6},
    {OP_WR, 1'b0, 16'h002F, 8'hAB, 4'd6},
    {OP_RD, 1'b0, 16'h002F, 8'hAB, 4'd6},
    {OP_WR, 1'b0, 16'h002E, 8'h07, 4'd9},  // R9 unsupported device 5
    {OP_WR, 1'b0, 16'h002F, 8'h05, 4'd9},
    {OP_WR, 1'b0, 16'h002E, 8'h60, 4'd9},
    {OP_RD, 1'b0, 16'h002F, 8'hFF, 4'd9},
    {OP_WR, 1'b0, 16'h002F, 8'h55, 4'd9},
    {OP_WR, 1'b0, 16'h002E, 8'h07, 4'd9},
    {OP_WR, 1'b0, 16'h002F, 8'h02, 4'd9},
    {OP_WR, 1'b0, 16'h002E, 8'h60, 4'd9},
    {OP_RD, 1'b0, 16'h002F, 8'h12, 4'd9},
    {OP_WR, 1'b0, 16'h002E, 8'h20, 4'd5},  // R5 global unimplemented
    {OP_WR, 1'b0, 16'h002F, 8'h77, 4'd5},
    {OP_RD, 1'b0, 16'h002F, 8'h00, 4'd5},
    {OP_WR, 1'b0, 16'h002E, 8'h07, 4'd4},
    {OP_RD, 1'b0, 16'h002F, 8'h02, 4'd4},
    {OP_WR, 1'b0, 16'h002E, 8'h70, 4'd10}, // R10 banked unimplemented
    {OP_WR, 1'b0, 16'h002F, 8'h99, 4'd10},
    {OP_RD, 1'b0, 16'h002F, 8'h00, 4'd10},
    {OP_WR, 1'b0, 16'h002E, 8'h30, 4'd7},  // R7 upper bits not stored
    {OP_WR, 1'b0, 16'h002F, 8'hFE, 4'd7},
    {OP_RD, 1'b0, 16'h002F, 8'h00, 4'd7},
    {OP_WR, 1'b0, 16'h004E, 8'h61, 4'd1},  // R1 unselected pair ignored
    {OP_RD, 1'b0, 16'h002E, 8'h30, 4'd1},
    {OP_NR, 1'b0, 16'h004E, 8'h00, 4'd1},
    {OP_WR, 1'b1, 16'h004E, 8'h61, 4'd1},  // R1 alternate pair
    {OP_RD, 1'b1, 16'h004F, 8'h34, 4'd1},
    {OP_NR, 1'b1, 16'h002E, 8'h00, 4'd1},
    {OP_WR, 1'b1, 16'h002F, 8'h00, 4'd1},
    {OP_RD, 1'b1, 16'h004F, 8'h34, 4'd1},
    {OP_NR, 1'b0, 16'h004F, 8'h00, 4'd1}
  };

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [15:0]             ioAddr = '0;
  logic                    ioWr = 1'b0;
  logic                    ioRd = 1'b0;
  logic [7:0]              ioWdata = '0;
  logic                    altPortSel = 1'b0;
  logic [7:0]              ioRdata;
  logic                    ioRdValid;
  logic [NUM_DEV*16-1:0]   devBase;
  logic [NUM_DEV-1:0]      devBaseValid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cfg_index_bank u_cfg_index_bank (
    .clk          (clk),
    .rstN         (rstN),
    .ioAddr       (ioAddr),
    .ioWr         (ioWr),
    .ioRd         (ioRd),
    .ioWdata      (ioWdata),
    .altPortSel   (altPortSel),
    .ioRdata      (ioRdata),
    .ioRdValid    (ioRdValid),
    .devBase      (devBase),
    .devBaseValid (devBaseValid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access: driven at a falling edge, held over one rising edge, sampled at the next falling edge
  task automatic access(input logic [1:0] op, input logic alt, input logic [15:0] addr,
                        input logic [7:0] data);
    @(negedge clk);
    altPortSel = alt;
    ioAddr     = addr;
    ioWr       = (op == OP_WR);
    ioRd       = (op != OP_WR);
    ioWdata    = (op == OP_WR) ? data : 8'h00;
    @(negedge clk);
    ioWr = 1'b0;
    ioRd = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 rdValid", 64'(ioRdValid), 64'd0);
    check("R11 devBase", 64'(devBase), 64'd0);
    check("R11 devBaseValid", 64'(devBaseValid), 64'd0);
    rstN = 1'b1;
    access(OP_RD, 1'b0, 16'h002E, 8'h00);
    check("R11 index after reset", 64'(ioRdata), 64'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  op;
      logic        alt;
      logic [15:0] addr;
      logic [7:0]  dat;
      logic [3:0]  req;
      {op, alt, addr, dat, req} = VEC[i];
      access(op, alt, addr, dat);
      if (op == OP_RD) begin
        check($sformatf("R%0d vec%0d valid", req, i), 64'(ioRdValid), 64'd1);
        check($sformatf("R%0d vec%0d data", req, i), 64'(ioRdata), 64'(dat));
      end else if (op == OP_NR) begin
        check($sformatf("R%0d vec%0d no response", req, i), 64'({ioRdValid, ioRdata}), 64'd0);
      end
    end

    // R8 exported base values, device 2 disabled by the FEh write
    check("R8 dev2 base", 64'(devBase[47:32]), 64'h1234);
    check("R8 valid all clear", 64'(devBaseValid), 64'h0);
    // R9 write under device 5 reached no device
    check("R9 dev1 base kept", 64'(devBase[31:16]), 64'hAB00);
    check("R9 dev3 untouched", 64'(devBase[63:48]), 64'h0000);

    // R8 enabling device 2 raises only its valid bit right after the write edge
    access(OP_WR, 1'b0, 16'h002E, 8'h30);
    access(OP_WR, 1'b0, 16'h002F, 8'h01);
    check("R8 dev2 valid", 64'(devBaseValid), 64'b0100);

    // R3 read timing: valid for exactly one cycle, data zero afterwards
    @(negedge clk);
    altPortSel = 1'b0;
    ioAddr     = 16'h002E;
    ioRd       = 1'b1;
    #1;
    check("R3 not valid before edge", 64'(ioRdValid), 64'd0);
    @(negedge clk);
    ioRd = 1'b0;
    check("R3 valid after edge", 64'({ioRdValid, ioRdata}), 64'h130);
    @(negedge clk);
    check("R3 valid drops", 64'({ioRdValid, ioRdata}), 64'h000);

    // R11 reset in mid-run clears everything
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R11 devBase cleared", 64'(devBase), 64'd0);
    check("R11 valid cleared", 64'(devBaseValid), 64'd0);
    access(OP_RD, 1'b0, 16'h002E, 8'h00);
    check("R11 index cleared", 64'(ioRdata), 64'h00);
    access(OP_WR, 1'b0, 16'h002E, 8'h07);
    access(OP_RD, 1'b0, 16'h002F, 8'h00);
    check("R11 device select cleared", 64'({ioRdValid, ioRdata}), 64'h100);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule